// File: doc/BRIEF.md
# Interlaced and Stereo Field Timing Generator

This block produces the raster timing for a parallel pixel output: horizontal sync, vertical sync, data enable, the pixel and line offsets inside the visible area, and tags for field parity and stereo eye. Each line is built from four programmable horizontal spans. Each field uses one of four vertical parameter sets. The active set follows a fixed rotation that two mode controls choose. With both controls off the output is progressive. One control gives interlaced fields, the other gives frame-packed stereo, and the two together give interlaced stereo.

A set can move its vertical sync by half a line, so that even fields of an interlaced picture line up correctly. Each output can have its active level inverted. A software reset holds the counters at the start of the first field while configuration is loaded. An enable freezes the raster and drives every output to its idle level. In interlaced modes the programmed active height is the height of one field.

Top module: `field_timing_gen`

## Requirements
- R1: A line lasts h_sync_len + h_back_len + h_act_len + h_front_len pixel clocks. The raw horizontal sync is active during its first h_sync_len pixels.
- R2: Raw data enable is active only on pixels h_sync_len + h_back_len up to that value + h_act_len − 1, and only on lines sync + back up to that value + v_act_len − 1 of the current set. Inside that region hpos_o and vpos_o give the offset from its first pixel and first line. Outside it they are 0.
- R3: A field using set n lasts sync + back + v_act_len + front lines, with set n occupying bits [n*VW +: VW] of each vertical bus. Without the half flag, raw vertical sync is active for the first sync lines.
- R4: When v_half[n] is set, vertical sync starts at pixel floor(line length / 2) of line 0 and ends at the same pixel of line sync.
- R5: The set index is {eye_o, field_o}: field_o 1 means even field and eye_o 1 means right eye. With both modes off, every field uses set 0. With il_mode only, the order is 0,1,0,1. With st_mode only, the order is 0,2,0,2. With both modes on, the order is 0,1,2,3.
- R6: pol_inv bit 0 inverts de_o, bit 1 inverts hsync_o and bit 2 inverts vsync_o. pclk_inv_o carries bit 3, one clock later.
- R7: While soft_rst is high, the counters are cleared and the outputs sit at their idle level. The first clock edge with soft_rst low presents line 0, pixel 0 of set 0 on the outputs.
- R8: While enable is low (and soft_rst is low), the counters hold their position and the outputs sit at their idle level. The idle level is the polarity bit for sync and enable, and 0 for field_o, eye_o, hpos_o and vpos_o. When enable returns high, the raster continues from where it stopped.
- R9: While rst_n is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Global run enable |
| soft_rst | input | 1 | Software reset; holds the counters at the start of the first field |
| il_mode | input | 1 | Interlaced field rotation |
| st_mode | input | 1 | Stereo eye rotation |
| h_sync_len | input | HW | Horizontal sync width in pixels |
| h_back_len | input | HW | Horizontal back porch in pixels |
| h_act_len | input | HW | Active width in pixels |
| h_front_len | input | HW | Horizontal front porch in pixels |
| v_act_len | input | VW | Active lines per field |
| v_sync_len | input | 4*VW | Vertical sync lines, one slice per set |
| v_back_len | input | 4*VW | Vertical back porch lines, one slice per set |
| v_front_len | input | 4*VW | Vertical front porch lines, one slice per set |
| v_half | input | 4 | Half-line vertical sync shift, one bit per set |
| pol_inv | input | 4 | Output inversion: de, hsync, vsync, clock edge |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| pclk_inv_o | output | 1 | Output clock edge select |
| field_o | output | 1 | Field parity tag (1 = even) |
| eye_o | output | 1 | Stereo eye tag (1 = right) |
| hpos_o | output | HW | Pixel offset in the active area |
| vpos_o | output | VW | Line offset in the active area |

## Verification
The hardest state to reach from the ports is the right-eye even field in interlaced stereo mode. It is the only place where the fourth set, its half-line shift and the wrap of the rotation back to set 0 all meet, and it is reached only after three complete fields. The stimulus loads every set with a different sync length and marks only the even sets for half-line shift, so a wrong set or a wrong shift shows as a different vsync edge. From a software reset, each mode is run for four full fields plus one line, and every output is compared on every clock. After the mode runs, the enable is dropped in the middle of a field and a software reset is pulsed mid-raster, to test the freeze and the restart.

// File: rtl/ftg_pkg.sv
package ftg_pkg;
  parameter int unsigned HW = 12;
  parameter int unsigned VW = 11;
  localparam int unsigned NSETS = 4;
  localparam int unsigned SW = $clog2(NSETS);
  localparam int unsigned NPOL = 4;
  localparam int unsigned POL_DE = 0;
  localparam int unsigned POL_HS = 1;
  localparam int unsigned POL_VS = 2;
  localparam int unsigned POL_CK = 3;

  typedef logic [HW-1:0] hval_t;
  typedef logic [VW-1:0] vval_t;
  typedef logic [SW-1:0] sel_t;

  typedef struct packed {
    vval_t sync;
    vval_t back;
    vval_t front;
    logic  half;
  } vset_t;

  function automatic hval_t line_total(input hval_t s, input hval_t b,
                                       input hval_t a, input hval_t f);
    return s + b + a + f;
  endfunction

  function automatic hval_t half_line(input hval_t tot);
    return tot >> 1;
  endfunction

  function automatic vval_t field_total(input vset_t v, input vval_t act);
    return v.sync + v.back + act + v.front;
  endfunction

  // set index is {eye, field}
  function automatic sel_t next_set(input sel_t cur, input logic il, input logic st);
    case ({st, il})
      2'b11:   return cur + 1'b1;
      2'b01:   return {1'b0, ~cur[0]};
      2'b10:   return {~cur[1], 1'b0};
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/ftg_hcount.sv
module ftg_hcount
  import ftg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clr,
  input  logic  run,
  input  hval_t sync_len,
  input  hval_t back_len,
  input  hval_t act_len,
  input  hval_t front_len,
  output hval_t hcnt,
  output hval_t hhalf,
  output hval_t hofs,
  output logic  line_end,
  output logic  hs_raw,
  output logic  h_act
);
  hval_t htot;
  hval_t act_start;

  assign htot      = line_total(sync_len, back_len, act_len, front_len);
  assign hhalf     = half_line(htot);
  assign act_start = sync_len + back_len;
  assign line_end  = (hcnt == htot - 1'b1);
  assign hs_raw    = (hcnt < sync_len);
  assign h_act     = (hcnt >= act_start) && (hcnt < act_start + act_len);
  assign hofs      = hcnt - act_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hcnt <= '0;
    else if (clr)    hcnt <= '0;
    else if (run)    hcnt <= line_end ? '0 : hcnt + 1'b1;
  end

  // R1
  line_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (hcnt < htot));
endmodule

// File: rtl/ftg_vcount.sv
module ftg_vcount
  import ftg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               run,
  input  logic               line_end,
  input  hval_t              hcnt,
  input  hval_t              hhalf,
  input  logic               il_mode,
  input  logic               st_mode,
  input  vval_t              act_len,
  input  logic [NSETS*VW-1:0] sync_bus,
  input  logic [NSETS*VW-1:0] back_bus,
  input  logic [NSETS*VW-1:0] front_bus,
  input  logic [NSETS-1:0]   half_bits,
  output vval_t              vcnt,
  output sel_t               sel,
  output vval_t              vofs,
  output logic               vs_raw,
  output logic               v_act
);
  vset_t sets [NSETS];
  vset_t cur;
  vval_t vtot;
  vval_t act_start;
  logic  last_line;
  logic  field_end;

  for (genvar g = 0; g < NSETS; g++) begin : g_unpack
    assign sets[g] = '{sync:  sync_bus[g*VW +: VW],
                       back:  back_bus[g*VW +: VW],
                       front: front_bus[g*VW +: VW],
                       half:  half_bits[g]};
  end

  assign cur       = sets[sel];
  assign vtot      = field_total(cur, act_len);
  assign act_start = cur.sync + cur.back;
  assign last_line = (vcnt == vtot - 1'b1);
  assign field_end = line_end && last_line;
  assign v_act     = (vcnt >= act_start) && (vcnt < act_start + act_len);
  assign vofs      = vcnt - act_start;

  assign vs_raw = cur.half
    ? (((vcnt != '0) || (hcnt >= hhalf)) &&
       ((vcnt < cur.sync) || ((vcnt == cur.sync) && (hcnt < hhalf))))
    : (vcnt < cur.sync);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vcnt <= '0;
      sel  <= '0;
    end else if (clr) begin
      vcnt <= '0;
      sel  <= '0;
    end else if (run && line_end) begin
      if (last_line) begin
        vcnt <= '0;
        sel  <= next_set(sel, il_mode, st_mode);
      end else begin
        vcnt <= vcnt + 1'b1;
      end
    end
  end

  // R4
  half_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(vs_raw) && cur.half) |-> (hcnt == hhalf));

  // R5
  seq_il_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && field_end && il_mode && !st_mode) |=> ((sel[0] != $past(sel[0])) && !sel[1]));

  // R5
  seq_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && field_end && !il_mode && !st_mode) |=> (sel == '0));
endmodule

// File: rtl/ftg_outreg.sv
module ftg_outreg
  import ftg_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            hs_raw,
  input  logic            vs_raw,
  input  logic            de_raw,
  input  sel_t            sel,
  input  hval_t           hofs,
  input  vval_t           vofs,
  input  logic [NPOL-1:0] pol,
  output logic            hsync_o,
  output logic            vsync_o,
  output logic            de_o,
  output logic            pclk_inv_o,
  output logic            field_o,
  output logic            eye_o,
  output hval_t           hpos_o,
  output vval_t           vpos_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hsync_o    <= 1'b0;
      vsync_o    <= 1'b0;
      de_o       <= 1'b0;
      pclk_inv_o <= 1'b0;
      field_o    <= 1'b0;
      eye_o      <= 1'b0;
      hpos_o     <= '0;
      vpos_o     <= '0;
    end else begin
      hsync_o    <= (run & hs_raw) ^ pol[POL_HS];
      vsync_o    <= (run & vs_raw) ^ pol[POL_VS];
      de_o       <= (run & de_raw) ^ pol[POL_DE];
      pclk_inv_o <= pol[POL_CK];
      field_o    <= run & sel[0];
      eye_o      <= run & sel[1];
      hpos_o     <= (run && de_raw) ? hofs : '0;
      vpos_o     <= (run && de_raw) ? vofs : '0;
    end
  end

  // R8
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> ((de_o == $past(pol[POL_DE])) && (hsync_o == $past(pol[POL_HS])) &&
              (vsync_o == $past(pol[POL_VS])) && !field_o && !eye_o));

  // R6
  clk_pol_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pol[POL_CK] |=> pclk_inv_o);
endmodule

// File: rtl/field_timing_gen.sv
module field_timing_gen
  import ftg_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic                soft_rst,
  input  logic                il_mode,
  input  logic                st_mode,
  input  logic [HW-1:0]       h_sync_len,
  input  logic [HW-1:0]       h_back_len,
  input  logic [HW-1:0]       h_act_len,
  input  logic [HW-1:0]       h_front_len,
  input  logic [VW-1:0]       v_act_len,
  input  logic [NSETS*VW-1:0] v_sync_len,
  input  logic [NSETS*VW-1:0] v_back_len,
  input  logic [NSETS*VW-1:0] v_front_len,
  input  logic [NSETS-1:0]    v_half,
  input  logic [NPOL-1:0]     pol_inv,
  output logic                hsync_o,
  output logic                vsync_o,
  output logic                de_o,
  output logic                pclk_inv_o,
  output logic                field_o,
  output logic                eye_o,
  output logic [HW-1:0]       hpos_o,
  output logic [VW-1:0]       vpos_o
);
  logic  run;
  logic  line_end;
  logic  hs_raw;
  logic  h_act;
  logic  vs_raw;
  logic  v_act;
  logic  de_raw;
  hval_t hcnt;
  hval_t hhalf;
  hval_t hofs;
  vval_t vcnt;
  vval_t vofs;
  sel_t  sel;

  assign run    = enable && !soft_rst;
  assign de_raw = h_act && v_act;

  ftg_hcount u_h (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst), .run(run),
    .sync_len(h_sync_len), .back_len(h_back_len),
    .act_len(h_act_len), .front_len(h_front_len),
    .hcnt(hcnt), .hhalf(hhalf), .hofs(hofs),
    .line_end(line_end), .hs_raw(hs_raw), .h_act(h_act)
  );

  ftg_vcount u_v (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst), .run(run),
    .line_end(line_end), .hcnt(hcnt), .hhalf(hhalf),
    .il_mode(il_mode), .st_mode(st_mode), .act_len(v_act_len),
    .sync_bus(v_sync_len), .back_bus(v_back_len),
    .front_bus(v_front_len), .half_bits(v_half),
    .vcnt(vcnt), .sel(sel), .vofs(vofs),
    .vs_raw(vs_raw), .v_act(v_act)
  );

  ftg_outreg u_o (
    .clk(clk), .rst_n(rst_n), .run(run),
    .hs_raw(hs_raw), .vs_raw(vs_raw), .de_raw(de_raw),
    .sel(sel), .hofs(hofs), .vofs(vofs), .pol(pol_inv),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
    .pclk_inv_o(pclk_inv_o), .field_o(field_o), .eye_o(eye_o),
    .hpos_o(hpos_o), .vpos_o(vpos_o)
  );

  // R2
  de_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    de_raw |-> !hs_raw);

  // R7
  srst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> ((hcnt == '0) && (vcnt == '0) && (sel == '0)));

  // R8
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !soft_rst) |=> ($stable(hcnt) && $stable(vcnt) && $stable(sel)));
endmodule

// File: tb/field_timing_gen_test.sv
`timescale 1ns/1ps
module field_timing_gen_test;
  import ftg_pkg::*;

  localparam int HS = 2, HBP = 3, HA = 4, HFP = 2;
  localparam int HT = HS + HBP + HA + HFP;
  localparam int VBP = 1, VA = 3, VFP = 2;
  localparam logic [3:0] HALFMASK = 4'b1010;
  // {pol[3:0], il, st, rotation of four 2-bit set indices, field 0 in low bits}
  localparam logic [13:0] MODES [4] = '{
    {4'b0000, 1'b0, 1'b0, 8'h00},
    {4'b0111, 1'b1, 1'b0, 8'h44},
    {4'b1010, 1'b0, 1'b1, 8'h88},
    {4'b0101, 1'b1, 1'b1, 8'hE4}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_b = 1'b1, sr_b = 1'b1, il_b = 1'b0, st_b = 1'b0;
  logic [3:0] pol_b = 4'b1111;
  logic [7:0] seq_b = 8'h00;
  logic hsync_o, vsync_o, de_o, pclk_inv_o, field_o, eye_o;
  logic [HW-1:0] hpos_o;
  logic [VW-1:0] vpos_o;
  int total = 0, bad = 0;
  int bh = 0, bv = 0, bk = 0;
  bit done = 0;

  always #2 clk = ~clk;

  field_timing_gen uut (
    .clk(clk), .rst_n(rst_n), .enable(en_b), .soft_rst(sr_b),
    .il_mode(il_b), .st_mode(st_b),
    .h_sync_len(HW'(HS)), .h_back_len(HW'(HBP)),
    .h_act_len(HW'(HA)), .h_front_len(HW'(HFP)),
    .v_act_len(VW'(VA)),
    .v_sync_len({VW'(4), VW'(3), VW'(2), VW'(1)}),
    .v_back_len({4{VW'(VBP)}}),
    .v_front_len({4{VW'(VFP)}}),
    .v_half(HALFMASK), .pol_inv(pol_b),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
    .pclk_inv_o(pclk_inv_o), .field_o(field_o), .eye_o(eye_o),
    .hpos_o(hpos_o), .vpos_o(vpos_o)
  );

  function automatic int vs_of(input int i);
    return i + 1;
  endfunction

  function automatic int vt_of(input int i);
    return vs_of(i) + VBP + VA + VFP;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic tick();
    logic run, hs, vs, de;
    int i, p, st, h0, v0;
    string tg;
    @(posedge clk); #1;
    run = en_b && !sr_b;
    i = int'(seq_b[2*bk +: 2]);
    h0 = HS + HBP;
    v0 = vs_of(i) + VBP;
    hs = (bh < HS);
    p = bv * HT + bh;
    st = HALFMASK[i] ? HT / 2 : 0;
    vs = (p >= st) && (p < vs_of(i) * HT + st);
    de = (bh >= h0) && (bh < h0 + HA) && (bv >= v0) && (bv < v0 + VA);
    if (run) begin
      tg = HALFMASK[i] ? "R4" : "R3";
      chk("R1", "hsync", hsync_o, hs ^ pol_b[1]);
      chk(tg, "vsync", vsync_o, vs ^ pol_b[2]);
      chk("R2", "de", de_o, de ^ pol_b[0]);
      chk("R2", "hpos", hpos_o, de ? bh - h0 : 0);
      chk("R2", "vpos", vpos_o, de ? bv - v0 : 0);
      chk("R5", "field", field_o, i % 2);
      chk("R5", "eye", eye_o, i / 2);
    end else begin
      tg = sr_b ? "R7" : "R8";
      chk(tg, "hsync idle", hsync_o, pol_b[1]);
      chk(tg, "vsync idle", vsync_o, pol_b[2]);
      chk(tg, "de idle", de_o, pol_b[0]);
      chk(tg, "field idle", field_o, 0);
      chk(tg, "eye idle", eye_o, 0);
      chk(tg, "hpos idle", hpos_o, 0);
    end
    chk("R6", "pclk_inv", pclk_inv_o, pol_b[3]);
    if (sr_b) begin
      bh = 0; bv = 0; bk = 0;
    end else if (en_b) begin
      if (bh == HT - 1) begin
        bh = 0;
        if (bv == vt_of(i) - 1) begin
          bv = 0;
          bk = (bk + 1) % 4;
        end else bv++;
      end else bh++;
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: got 0 expected 1 (run finished)");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int cyc;
    repeat (3) @(posedge clk);
    #1;
    // R9: reset state, even with every inversion bit set
    chk("R9", "hsync reset", hsync_o, 0);
    chk("R9", "vsync reset", vsync_o, 0);
    chk("R9", "de reset", de_o, 0);
    chk("R9", "pclk reset", pclk_inv_o, 0);
    chk("R9", "field reset", field_o, 0);
    chk("R9", "hpos reset", hpos_o, 0);
    rst_n = 1'b1;
    tick();
    tick();

    // table of modes: each run four full fields from soft reset
    for (int m = 0; m < 4; m++) begin
      {pol_b, il_b, st_b, seq_b} = MODES[m];
      sr_b = 1'b1;
      tick();
      tick();
      sr_b = 1'b0;
      cyc = HT;
      for (int k = 0; k < 4; k++) cyc += vt_of(int'(seq_b[2*k +: 2])) * HT;
      repeat (cyc) tick();
    end

    // R8: freeze mid-field in interlaced stereo, then resume
    repeat (37) tick();
    en_b = 1'b0;
    repeat (6) tick();
    en_b = 1'b1;
    repeat (60) tick();

    // R7: soft reset in the middle of the raster restarts at set 0
    sr_b = 1'b1;
    tick();
    sr_b = 1'b0;
    tick();
    chk("R7", "restart field", field_o, 0);
    chk("R7", "restart eye", eye_o, 0);
    chk("R7", "restart hsync active", hsync_o, 1 ^ pol_b[1]);
    repeat (30) tick();

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule